// File: doc/BRIEF.md
# Funnel Shift Unit

This block shifts or rotates a data word by a variable amount. Every shift kind runs on one datapath: a funnel that extracts a word-wide window from the concatenation of an upper word and a lower word, at a right offset from zero to one less than the word width. A small control stage picks the upper word, the lower word and the offset for the requested operation. It produces logical right, arithmetic right, logical left, rotate right and rotate left from that one extractor.

The funnel core is a cascade of 2:1 multiplexer stages. The stage of weight 2^k moves the window right by 2^k positions when bit k of the offset is set. The result is captured in an output register. A caller presents the operand, shift amount and operation code in one cycle and reads the result after the next rising clock edge. The word width is a parameter and must be a power of two. The default is 32 bits, with a 5-bit shift amount.

Top module: `funnel_shift_unit`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `result` becomes zero on that edge.
- R2: `result` is registered. Inputs present at a rising edge appear on `result` after that edge, and `result` keeps its value until the next edge.
- R3: Operation code 3'b000 is a logical right shift. The operand moves right by `shamt` places and zeros fill the vacated upper bits.
- R4: Operation code 3'b001 is an arithmetic right shift. The operand moves right by `shamt` places and copies of operand bit 31 fill the vacated upper bits.
- R5: Operation code 3'b010 is a logical left shift. The operand moves left by `shamt` places and zeros fill the vacated lower bits.
- R6: Operation code 3'b011 rotates the operand right by `shamt` places. Bits leaving bit 0 re-enter at bit 31.
- R7: Operation code 3'b100 rotates the operand left by `shamt` places. Bits leaving bit 31 re-enter at bit 0.
- R8: A shift amount of zero passes the operand through unchanged for each of the five operation codes.
- R9: Operation codes 3'b101, 3'b110 and 3'b111 produce a zero result, whatever the operand and amount.
- R10: The largest shift amount, 31, gives the correct result for all five operations. For example, a logical right shift leaves only the former bit 31, in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code (see R3 to R7, R9) |
| shamt | input | 5 | Shift or rotate amount, 0 to 31 |
| operand | input | 32 | Data word to shift |
| result | output | 32 | Registered shifted or rotated word |

## Verification
Some properties are checked on every cycle against the inputs of the previous cycle:
- a zero amount passes the operand through;
- rotates keep the count of set bits;
- a logical right shift clears the top bit, and an arithmetic right shift copies the old sign there;
- a left shift clears bit 0;
- unused codes give zero;
- reset clears the output.

Only the bench's directed scenarios can show the exact bit positions of each shifted word, the wrap-around of rotates at amounts 1 and 31, and the one-cycle latency of the output register.

// File: rtl/funnel_shift_pkg.sv
package funnel_shift_pkg;

  typedef enum logic [2:0] {
    SH_LSR = 3'b000,
    SH_ASR = 3'b001,
    SH_LSL = 3'b010,
    SH_ROR = 3'b011,
    SH_ROL = 3'b100
  } shift_kind_e;

endpackage

// File: rtl/funnel_select.sv
// Chooses upper word, lower word and right offset for the funnel.
module funnel_select #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [2:0]       kind,
  input  logic [SHW-1:0]   amount,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] upper,
  output logic [WIDTH-1:0] lower,
  output logic [SHW-1:0]   offset,
  output logic             legal
);
  import funnel_shift_pkg::*;

  logic [SHW-1:0] neg_amount;
  logic           amount_zero;

  // (WIDTH - amount) mod WIDTH, valid because WIDTH is a power of two
  assign neg_amount  = SHW'(0) - amount;
  assign amount_zero = (amount == '0);

  always_comb begin
    upper  = '0;
    lower  = '0;
    offset = '0;
    legal  = 1'b1;
    case (kind)
      SH_LSR: begin
        lower  = data;
        offset = amount;
      end
      SH_ASR: begin
        upper  = {WIDTH{data[WIDTH-1]}};
        lower  = data;
        offset = amount;
      end
      SH_LSL: begin
        if (amount_zero) begin
          lower = data;
        end else begin
          upper  = data;
          offset = neg_amount;
        end
      end
      SH_ROR: begin
        upper  = data;
        lower  = data;
        offset = amount;
      end
      SH_ROL: begin
        upper  = data;
        lower  = data;
        offset = neg_amount;
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/funnel_core.sv
// Right-extracting funnel: log2(WIDTH) stages of 2:1 multiplexers.
module funnel_core #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH),
  localparam int DW  = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] upper,
  input  logic [WIDTH-1:0] lower,
  input  logic [SHW-1:0]   offset,
  output logic [WIDTH-1:0] window
);

  logic [DW-1:0] stage [0:SHW];

  assign stage[0] = {upper, lower};

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = offset[k] ? (stage[k] >> STEP) : stage[k];
  end

  assign window = stage[SHW][WIDTH-1:0];

endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_sel,
  input  logic [SHW-1:0]   shamt,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result
);
  import funnel_shift_pkg::*;

  logic [WIDTH-1:0] upper_w;
  logic [WIDTH-1:0] lower_w;
  logic [SHW-1:0]   offset_w;
  logic             legal_w;
  logic [WIDTH-1:0] window_w;

  funnel_select #(.WIDTH(WIDTH)) u_select (
    .kind   (op_sel),
    .amount (shamt),
    .data   (operand),
    .upper  (upper_w),
    .lower  (lower_w),
    .offset (offset_w),
    .legal  (legal_w)
  );

  funnel_core #(.WIDTH(WIDTH)) u_core (
    .upper  (upper_w),
    .lower  (lower_w),
    .offset (offset_w),
    .window (window_w)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= legal_w ? window_w : '0;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> result == '0);

  // R8
  a_r8_zero_pass: assert property (@(posedge clk) disable iff (rst)
    (shamt == '0 && op_sel <= 3'b100) |=> result == $past(operand));

  // R6 R7
  a_r6_r7_rot_ones: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b011 || op_sel == 3'b100)
      |=> $countones(result) == $countones($past(operand)));

  // R3
  a_r3_lsr_top_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b000 && shamt != '0) |=> result[WIDTH-1] == 1'b0);

  // R4
  a_r4_asr_sign: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b001) |=> result[WIDTH-1] == $past(operand[WIDTH-1]));

  // R5
  a_r5_lsl_low_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b010 && shamt != '0) |=> result[0] == 1'b0);

  // R9
  a_r9_bad_code_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 3'b100) |=> result == '0);

endmodule

// File: tb/test_funnel_shift_unit.sv
module test_funnel_shift_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] operand = '0;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  funnel_shift_unit i_funnel_shift_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .shamt(shamt),
    .operand(operand), .result(result)
  );

  function automatic logic [31:0] model(input logic [2:0] op, input logic [4:0] n,
                                        input logic [31:0] a);
    int s;
    s = int'(n);
    case (op)
      3'b000: model = a >> s;
      3'b001: model = 32'($signed(a) >>> s);
      3'b010: model = a << s;
      3'b011: model = (s == 0) ? a : ((a >> s) | (a << (32 - s)));
      3'b100: model = (s == 0) ? a : ((a << s) | (a >> (32 - s)));
      default: model = '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(input string req, input logic [2:0] op, input logic [4:0] n,
                       input logic [31:0] a);
    op_sel = op; shamt = n; operand = a;
    @(negedge clk);
    check(req, result, model(op, n, a));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", result, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_lsr;
    apply("R3", 3'b000, 5'd4, 32'hF000_00F0);
    apply("R3", 3'b000, 5'd17, 32'hDEAD_BEEF);
  endtask

  task automatic t_asr;
    apply("R4", 3'b001, 5'd8, 32'h8123_4567);
    apply("R4", 3'b001, 5'd8, 32'h7123_4567);
  endtask

  task automatic t_lsl;
    apply("R5", 3'b010, 5'd1, 32'h8000_0001);
    apply("R5", 3'b010, 5'd12, 32'h1234_5678);
  endtask

  task automatic t_ror;
    apply("R6", 3'b011, 5'd1, 32'h0000_0001);
    apply("R6", 3'b011, 5'd20, 32'hCAFE_F00D);
  endtask

  task automatic t_rol;
    apply("R7", 3'b100, 5'd1, 32'h8000_0000);
    apply("R7", 3'b100, 5'd9, 32'hCAFE_F00D);
  endtask

  task automatic t_zero;
    for (int op = 0; op < 5; op++) begin
      op_sel = 3'(op); shamt = 5'd0; operand = 32'hA5C3_0F81;
      @(negedge clk);
      check("R8", result, 32'hA5C3_0F81);
    end
  endtask

  task automatic t_bad_code;
    for (int op = 5; op < 8; op++) begin
      op_sel = 3'(op); shamt = 5'd3; operand = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R9", result, 32'h0);
    end
  endtask

  task automatic t_max;
    apply("R10", 3'b000, 5'd31, 32'h8000_0000);
    check("R10", result, 32'h0000_0001);
    apply("R10", 3'b001, 5'd31, 32'h8000_0000);
    check("R10", result, 32'hFFFF_FFFF);
    apply("R10", 3'b010, 5'd31, 32'h0000_0003);
    check("R10", result, 32'h8000_0000);
    apply("R10", 3'b011, 5'd31, 32'h8000_0001);
    check("R10", result, 32'h0000_0003);
    apply("R10", 3'b100, 5'd31, 32'h8000_0001);
    check("R10", result, 32'hC000_0000);
  endtask

  task automatic t_latency;
    logic [31:0] prev;
    apply("R2", 3'b011, 5'd4, 32'h0000_00AB);
    prev = result;
    op_sel = 3'b000; shamt = 5'd4; operand = 32'h0000_00F0;
    #1;
    check("R2", result, prev);
    @(negedge clk);
    check("R2", result, 32'h0000_000F);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_lsr();
    t_asr();
    t_lsl();
    t_ror();
    t_rol();
    t_zero();
    t_bad_code();
    t_max();
    t_latency();
    op_sel = 3'b000; operand = 32'h1234_5678;
    rst = 1'b1;
    @(negedge clk);
    check("R1", result, 32'h0);
    rst = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule